// File: doc/BRIEF.md
# Dual-Mode Serial Register Control Port

This block is the slave side of a control port that loads a small register file from a host. The host can use either a two-wire I2C bus or a write-only SPI-style port with clock, data and chip select. After reset the port listens on I2C. One shared pin serves as the low bit of the I2C device address. Its first falling edge after reset switches the port to SPI for good, and the pin then acts as the active-low chip select.

Every transfer first loads a memory address pointer byte. Bit 7 of that byte enables auto-increment, and bits 6:0 select a register. Data bytes after it are written to the parallel register-file port. I2C reads return bytes from the register selected by the pointer. All serial pins are sampled by the system clock through synchronizers, so the port runs independently of any audio clock.

The register file itself sits outside the block. It sees an address, write data and a write strobe, and it returns read data for the current address without delay. Registers with an address above `REG_COUNT-1` do not exist.

Top module: `dual_serial_regport`

## Requirements
- R1: After reset `sda_oe_o` is 0, `reg_we_o` is 0 and `spi_mode_o` is 0 (I2C mode). The pointer is 0 with auto-increment off.
- R2: The I2C device address is binary 001100 followed by the level of `adsel_i` taken just after reset. A matching address byte is acknowledged by pulling SDA low during the 9th clock. A non-matching address gets no ACK, and the rest of that transfer is ignored.
- R3: An I2C write is an address byte with R/W=0, then a pointer byte, then data bytes. Every byte is acknowledged. Each data byte gives exactly one `reg_we_o` pulse, with `reg_addr_o` equal to the pointer.
- R4: Pointer byte bit 7 is the auto-increment flag and bits 6:0 are the register address. With the flag at 0 the pointer stays the same for every data byte, for reads and for writes.
- R5: With the flag at 1 the pointer moves up by one after each data byte, for writes and for reads.
- R6: An I2C read (R/W=1) begins at the pointer left by earlier traffic. Bytes go out MSB first. A new byte follows each master ACK, and a master NACK ends the read.
- R7: A read from an address above `REG_COUNT-1` returns 0x00. A write to such an address gives no `reg_we_o` pulse, although the byte is still acknowledged.
- R8: The first falling edge on `adsel_i` after reset sets `spi_mode_o` to 1. It stays at 1 until reset, whatever later edges occur.
- R9: In SPI mode a frame lasts while `adsel_i` is low. Bits are taken on rising `cclk_i`, MSB first. The first byte must be 0x30, or the frame is ignored. The second byte is the pointer, and every later byte is a data write.
- R10: In SPI mode, traffic on SCL/SDA is ignored: SDA is never driven and no write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | I2C clock |
| sda_i | input | 1 | I2C data as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| cclk_i | input | 1 | SPI clock |
| cdin_i | input | 1 | SPI data in |
| adsel_i | input | 1 | I2C address bit, later the SPI chip select (active low) |
| spi_mode_o | output | 1 | 1 once the port has switched to SPI |
| reg_addr_o | output | 7 | Register address (current pointer) |
| reg_wdata_o | output | 8 | Register write data |
| reg_we_o | output | 1 | Single-cycle register write strobe |
| reg_rdata_i | input | 8 | Read data for `reg_addr_o`, no delay |

## Verification
A corrupted pointer appears on `reg_addr_o` at the very next write strobe, at the end of the following data byte. The scoreboard compares each strobe's address and data in order. A wrong byte-phase or ACK state shows up within one bus byte as a missing ACK on the 9th clock, or as a read byte with shifted bits. A mode latch that drops back shows as SDA being driven or a write strobe during I2C traffic sent after the switch. A missing range gate shows as 0xAA read back from a register that does not exist.

// File: rtl/ctrl_port_pkg.sv
// Package: constants and types shared by the dual-mode control port.
package ctrl_port_pkg;
    localparam int          PTR_W         = 7;          // register address bits in the pointer byte
    localparam logic [5:0]  DEV_ID_HI     = 6'b001100;  // fixed upper device-address bits
    localparam logic [7:0]  SPI_CHIP_BYTE = 8'h30;      // required first byte of an SPI frame

    typedef enum logic [2:0] {
        I2C_IDLE,
        I2C_RX,
        I2C_RXACK,
        I2C_TX,
        I2C_TXACK
    } i2c_state_t;

    typedef enum logic [1:0] {
        BK_ADDR,
        BK_MAP,
        BK_DATA
    } byte_kind_t;
endpackage

// File: rtl/pin_sync.sv
// pin_sync: multi-stage synchronizer with edge detection for asynchronous pins.
// Assumes inputs change slowly relative to clk. Edges are reported only after
// the chain has filled following reset, so reset values never look like edges.
module pin_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall,
    output logic             primed
);
    localparam int FILL_MAX = STAGES + 1;
    localparam int FILL_W   = $clog2(FILL_MAX + 1);

    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] prev_q;
    logic [FILL_W-1:0] fill_q;

    // First stage captures the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= din;
    end

    genvar gi;
    generate
        for (gi = 1; gi < STAGES; gi++) begin : g_stage
            // Further stages shift the sampled value toward the output.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[gi] <= '0;
                else        stage_q[gi] <= stage_q[gi-1];
            end
        end
    endgenerate

    // Remember the previous level and count fill cycles after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            fill_q <= '0;
        end else begin
            prev_q <= stage_q[STAGES-1];
            if (fill_q != FILL_W'(FILL_MAX)) fill_q <= fill_q + 1'b1;
        end
    end

    assign primed = (fill_q == FILL_W'(FILL_MAX));
    assign lvl    = stage_q[STAGES-1];
    assign rise   = primed ? (lvl & ~prev_q) : '0;
    assign fall   = primed ? (~lvl & prev_q) : '0;
endmodule

// File: rtl/map_ptr.sv
// map_ptr: memory address pointer with auto-increment flag.
// A load takes bit 7 as the increment flag and bits 6:0 as the address.
// An advance moves the address up by one only when the flag is set, and it
// stops at the top code so it never wraps back onto real registers.
module map_ptr
    import ctrl_port_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             map_ld,
    input  logic [7:0]       map_val,
    input  logic             adv,
    output logic [PTR_W-1:0] ptr,
    output logic             incr
);
    // Load or advance the pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr  <= '0;
            incr <= 1'b0;
        end else if (map_ld) begin
            incr <= map_val[7];
            ptr  <= map_val[PTR_W-1:0];
        end else if (adv && incr && (ptr != '1)) begin
            ptr <= ptr + 1'b1;
        end
    end

    // R4: with increment off and no new load, the pointer holds.
    a_r4_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!map_ld && !incr) |=> $stable(ptr));
endmodule

// File: rtl/i2c_engine.sv
// i2c_engine: I2C slave byte engine working on synchronized SCL/SDA levels and edges.
// Receives the address, pointer and data bytes, drives ACKs and read data on
// SDA through an open-drain enable, and pulses map_ld / wr / rd_adv for the
// pointer unit. It assumes the bus is slow compared with clk and that no
// clock stretching is needed. When en is low it idles and releases SDA.
module i2c_engine
    import ctrl_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       scl_lvl,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       sda_lvl,
    input  logic       sda_rise,
    input  logic       sda_fall,
    input  logic [6:0] dev_addr,
    input  logic [7:0] rd_data,
    output logic       sda_oe,
    output logic       map_ld,
    output logic       wr,
    output logic       rd_adv,
    output logic [7:0] byte_o
);
    i2c_state_t st_q;
    byte_kind_t kind_q;
    logic [7:0] sh_q;
    logic [3:0] cnt_q;
    logic       rw_q;
    logic       nack_q;

    logic start_c, stop_c;
    assign start_c = scl_lvl && sda_fall;
    assign stop_c  = scl_lvl && sda_rise;
    assign byte_o  = sh_q;

    // Bus protocol state machine: shift bytes, answer ACKs, send read bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= I2C_IDLE;
            kind_q <= BK_ADDR;
            sh_q   <= '0;
            cnt_q  <= '0;
            rw_q   <= 1'b0;
            nack_q <= 1'b0;
            sda_oe <= 1'b0;
            map_ld <= 1'b0;
            wr     <= 1'b0;
            rd_adv <= 1'b0;
        end else begin
            map_ld <= 1'b0;
            wr     <= 1'b0;
            rd_adv <= 1'b0;
            if (!en || stop_c) begin
                st_q   <= I2C_IDLE;
                sda_oe <= 1'b0;
            end else if (start_c) begin
                st_q   <= I2C_RX;
                kind_q <= BK_ADDR;
                cnt_q  <= '0;
                sda_oe <= 1'b0;
            end else begin
                case (st_q)
                    I2C_RX: begin
                        if (scl_rise && cnt_q != 4'd8) begin
                            sh_q  <= {sh_q[6:0], sda_lvl};
                            cnt_q <= cnt_q + 4'd1;
                        end else if (scl_fall && cnt_q == 4'd8) begin
                            cnt_q <= '0;
                            case (kind_q)
                                BK_ADDR: begin
                                    if (sh_q[7:1] == dev_addr) begin
                                        rw_q   <= sh_q[0];
                                        sda_oe <= 1'b1;
                                        st_q   <= I2C_RXACK;
                                    end else begin
                                        st_q <= I2C_IDLE;
                                    end
                                end
                                BK_MAP: begin
                                    map_ld <= 1'b1;
                                    sda_oe <= 1'b1;
                                    st_q   <= I2C_RXACK;
                                end
                                default: begin
                                    wr     <= 1'b1;
                                    sda_oe <= 1'b1;
                                    st_q   <= I2C_RXACK;
                                end
                            endcase
                        end
                    end
                    I2C_RXACK: begin
                        if (scl_fall) begin
                            if (kind_q == BK_ADDR && rw_q) begin
                                sh_q   <= rd_data;
                                sda_oe <= ~rd_data[7];
                                cnt_q  <= 4'd1;
                                rd_adv <= 1'b1;
                                st_q   <= I2C_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                cnt_q  <= '0;
                                kind_q <= (kind_q == BK_ADDR) ? BK_MAP : BK_DATA;
                                st_q   <= I2C_RX;
                            end
                        end
                    end
                    I2C_TX: begin
                        if (scl_fall) begin
                            if (cnt_q == 4'd8) begin
                                sda_oe <= 1'b0;
                                st_q   <= I2C_TXACK;
                            end else begin
                                sda_oe <= ~sh_q[6];
                                sh_q   <= {sh_q[6:0], 1'b0};
                                cnt_q  <= cnt_q + 4'd1;
                            end
                        end
                    end
                    I2C_TXACK: begin
                        if (scl_rise) begin
                            nack_q <= sda_lvl;
                        end else if (scl_fall) begin
                            if (nack_q) begin
                                st_q <= I2C_IDLE;
                            end else begin
                                sh_q   <= rd_data;
                                sda_oe <= ~rd_data[7];
                                cnt_q  <= 4'd1;
                                rd_adv <= 1'b1;
                                st_q   <= I2C_TX;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R10: once disabled, the engine releases SDA by the next cycle.
    a_r10_release_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !sda_oe);
endmodule

// File: rtl/spi_engine.sv
// spi_engine: write-only SPI frame decoder on synchronized pins.
// While chip select is low, it shifts bits on rising clock edges, MSB first.
// Byte 0 must be the chip byte, or the frame is ignored. Byte 1 loads the
// pointer, and each later byte pulses a write. Chip select high ends the frame.
module spi_engine
    import ctrl_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       cs_lvl,
    input  logic       cs_fall,
    input  logic       sclk_rise,
    input  logic       sdin_lvl,
    output logic       map_ld,
    output logic       wr,
    output logic [7:0] byte_o
);
    logic [7:0] sh_q;
    logic [2:0] cnt_q;
    logic [1:0] idx_q;
    logic       bad_q;
    logic [7:0] nxt_c;

    assign nxt_c  = {sh_q[6:0], sdin_lvl};
    assign byte_o = sh_q;

    // Frame decoder: count bits and classify each completed byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            cnt_q  <= '0;
            idx_q  <= '0;
            bad_q  <= 1'b0;
            map_ld <= 1'b0;
            wr     <= 1'b0;
        end else begin
            map_ld <= 1'b0;
            wr     <= 1'b0;
            if (cs_lvl || cs_fall) begin
                cnt_q <= '0;
                idx_q <= '0;
                bad_q <= 1'b0;
            end else if (en && sclk_rise && !bad_q) begin
                sh_q  <= nxt_c;
                cnt_q <= cnt_q + 3'd1;
                if (cnt_q == 3'd7) begin
                    case (idx_q)
                        2'd0: begin
                            if (nxt_c == SPI_CHIP_BYTE) idx_q <= 2'd1;
                            else                        bad_q <= 1'b1;
                        end
                        2'd1: begin
                            map_ld <= 1'b1;
                            idx_q  <= 2'd2;
                        end
                        default: wr <= 1'b1;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/dual_serial_regport.sv
// dual_serial_regport: top of the dual-mode control port.
// Synchronizes all serial pins and latches the device-address bit after reset.
// It locks SPI mode on the first falling edge of the shared pin, steers the
// active engine's byte and strobes to the shared pointer, and gates register
// access to addresses below REG_COUNT. It assumes the register file answers
// reads for reg_addr_o without delay.
module dual_serial_regport
    import ctrl_port_pkg::*;
#(
    parameter int REG_COUNT   = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe_o,
    input  logic             cclk_i,
    input  logic             cdin_i,
    input  logic             adsel_i,
    output logic             spi_mode_o,
    output logic [PTR_W-1:0] reg_addr_o,
    output logic [7:0]       reg_wdata_o,
    output logic             reg_we_o,
    input  logic [7:0]       reg_rdata_i
);
    localparam int                NPIN    = 5;
    localparam int                P_SCL   = 0;
    localparam int                P_SDA   = 1;
    localparam int                P_CCLK  = 2;
    localparam int                P_CDIN  = 3;
    localparam int                P_SEL   = 4;
    localparam logic [PTR_W-1:0]  LAST    = PTR_W'(REG_COUNT - 1);

    logic [NPIN-1:0] s_lvl, s_rise, s_fall;
    logic            s_primed, primed_d, ad0_q, spi_q;
    logic            i_map_ld, i_wr, i_rd_adv, s_map_ld, s_wr;
    logic [7:0]      i_byte, s_byte, cur_byte, rd_gated;
    logic            map_ld_c, wr_c, in_range;
    logic            sync_unused;

    pin_sync #(.WIDTH(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .din({adsel_i, cdin_i, cclk_i, sda_i, scl_i}),
        .lvl(s_lvl), .rise(s_rise), .fall(s_fall), .primed(s_primed)
    );

    assign sync_unused = ^{s_rise[P_CDIN], s_fall[P_CDIN], s_lvl[P_CCLK],
                           s_fall[P_CCLK], s_rise[P_SEL]};

    // Capture the address bit once, when the synchronizer first holds valid data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            primed_d <= 1'b0;
            ad0_q    <= 1'b0;
        end else begin
            primed_d <= s_primed;
            if (s_primed && !primed_d) ad0_q <= s_lvl[P_SEL];
        end
    end

    // Lock SPI mode on the first falling edge of the shared pin.
    always_ff @(posedge clk) begin
        if (!rst_n)            spi_q <= 1'b0;
        else if (s_fall[P_SEL]) spi_q <= 1'b1;
    end

    i2c_engine u_i2c (
        .clk(clk), .rst_n(rst_n), .en(!spi_q),
        .scl_lvl(s_lvl[P_SCL]), .scl_rise(s_rise[P_SCL]), .scl_fall(s_fall[P_SCL]),
        .sda_lvl(s_lvl[P_SDA]), .sda_rise(s_rise[P_SDA]), .sda_fall(s_fall[P_SDA]),
        .dev_addr({DEV_ID_HI, ad0_q}), .rd_data(rd_gated),
        .sda_oe(sda_oe_o), .map_ld(i_map_ld), .wr(i_wr), .rd_adv(i_rd_adv),
        .byte_o(i_byte)
    );

    spi_engine u_spi (
        .clk(clk), .rst_n(rst_n), .en(spi_q),
        .cs_lvl(s_lvl[P_SEL]), .cs_fall(s_fall[P_SEL]),
        .sclk_rise(s_rise[P_CCLK]), .sdin_lvl(s_lvl[P_CDIN]),
        .map_ld(s_map_ld), .wr(s_wr), .byte_o(s_byte)
    );

    assign map_ld_c = spi_q ? s_map_ld : i_map_ld;
    assign wr_c     = spi_q ? s_wr     : i_wr;
    assign cur_byte = spi_q ? s_byte   : i_byte;

    map_ptr u_ptr (
        .clk(clk), .rst_n(rst_n),
        .map_ld(map_ld_c), .map_val(cur_byte),
        .adv(wr_c || (i_rd_adv && !spi_q)),
        .ptr(reg_addr_o), .incr()
    );

    // Range gate: registers above the last index neither take writes nor return data.
    always_comb begin
        in_range    = (reg_addr_o <= LAST);
        rd_gated    = in_range ? reg_rdata_i : 8'h00;
        reg_we_o    = wr_c && in_range;
        reg_wdata_o = cur_byte;
    end

    assign spi_mode_o = spi_q;

    // R8: SPI mode never clears without reset.
    a_r8_spi_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        spi_q |=> spi_q);
    // R7: no write strobe reaches a register that does not exist.
    a_r7_we_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |-> (reg_addr_o <= LAST));
    // R10: SDA stays released once SPI mode has settled.
    a_r10_no_sda_in_spi: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_q && $past(spi_q)) |-> !sda_oe_o);
    // R9: a pointer load and a write strobe never coincide.
    a_r9_ld_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(map_ld_c && wr_c));
endmodule

// File: tb/dual_serial_regport_tb_top.sv
// Scoreboard bench: drivers queue the expected register writes, a monitor
// pops and compares them on every write strobe.
module dual_serial_regport_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 20;  // quarter I2C bit, in clocks
    localparam int SQ         = 8;   // half SPI bit, in clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1, sda_m = 1'b1, cclk = 1'b0, cdin = 1'b0, adsel = 1'b1;
    logic       sda_oe, spi_mode, reg_we;
    logic [6:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic       sda_line;
    logic [7:0] model_regs [8];

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct { logic [6:0] a; logic [7:0] d; string tag; } wr_item_t;
    wr_item_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_line  = sda_m & ~sda_oe;
    assign reg_rdata = (reg_addr < 7'd8) ? model_regs[reg_addr[2:0]] : 8'hAA;

    dual_serial_regport dut_i (
        .clk(clk), .rst_n(rst_n),
        .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
        .cclk_i(cclk), .cdin_i(cdin), .adsel_i(adsel),
        .spi_mode_o(spi_mode),
        .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata), .reg_we_o(reg_we),
        .reg_rdata_i(reg_rdata)
    );

    // Register file model outside the block.
    always @(posedge clk) begin
        if (rst_n && reg_we && reg_addr < 7'd8) model_regs[reg_addr[2:0]] <= reg_wdata;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic expect_wr(input logic [6:0] a, input logic [7:0] d, input string tag);
        wr_item_t it;
        it.a = a; it.d = d; it.tag = tag;
        exp_q.push_back(it);
    endtask

    // Monitor: compare every write strobe with the head of the queue.
    always @(negedge clk) begin
        if (rst_n && reg_we) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7/R10", "unexpected write", {17'd0, reg_addr, reg_wdata}, 32'd0);
            end else begin
                wr_item_t it;
                it = exp_q.pop_front();
                check(reg_addr == it.a && reg_wdata == it.d, it.tag, "write addr/data",
                      {17'd0, reg_addr, reg_wdata}, {17'd0, it.a, it.d});
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; scl = 1'b1; wait_cyc(Q);
        sda_m = 1'b0; wait_cyc(Q);
        scl = 1'b0; wait_cyc(Q);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; wait_cyc(Q);
        scl = 1'b1; wait_cyc(Q);
        sda_m = 1'b1; wait_cyc(Q);
    endtask

    task automatic i2c_bit(input logic b, output logic r);
        sda_m = b; wait_cyc(Q);
        scl = 1'b1; wait_cyc(Q);
        r = sda_line; wait_cyc(Q);
        scl = 1'b0; wait_cyc(Q);
    endtask

    task automatic i2c_wbyte(input logic [7:0] v, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) i2c_bit(v[i], r);
        i2c_bit(1'b1, r);
        ack = ~r;
    endtask

    task automatic i2c_rbyte(input logic m_ack, output logic [7:0] v);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            i2c_bit(1'b1, r);
            v[i] = r;
        end
        i2c_bit(~m_ack, r);
    endtask

    task automatic spi_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) begin
            cdin = v[i]; wait_cyc(SQ);
            cclk = 1'b1; wait_cyc(SQ);
            cclk = 1'b0;
        end
    endtask

    task automatic spi_frame3(input logic [7:0] b0, input logic [7:0] b1,
                              input logic [7:0] b2, input logic [7:0] b3);
        adsel = 1'b0; wait_cyc(SQ);
        spi_byte(b0); spi_byte(b1); spi_byte(b2); spi_byte(b3);
        wait_cyc(SQ); adsel = 1'b1; wait_cyc(3*SQ);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic       ack;
        logic [7:0] rv;
        for (int i = 0; i < 8; i++) model_regs[i] = 8'h10 + 8'(i);
        wait_cyc(6);
        rst_n = 1'b1;
        wait_cyc(10);

        // R1: reset state
        check(sda_oe == 1'b0, "R1", "sda_oe after reset", {31'd0, sda_oe}, 0);
        check(reg_we == 1'b0, "R1", "reg_we after reset", {31'd0, reg_we}, 0);
        check(spi_mode == 1'b0, "R1", "spi_mode after reset", {31'd0, spi_mode}, 0);
        check(reg_addr == 7'd0, "R1", "pointer after reset", {25'd0, reg_addr}, 0);

        // R2/R3/R5: write with increment, address bit from adsel=1 -> 0x32
        i2c_start();
        i2c_wbyte(8'h32, ack); check(ack, "R2", "address ACK", {31'd0, ack}, 1);
        i2c_wbyte(8'h82, ack); check(ack, "R3", "pointer ACK", {31'd0, ack}, 1);
        expect_wr(7'd2, 8'hA1, "R3");
        i2c_wbyte(8'hA1, ack); check(ack, "R3", "data ACK", {31'd0, ack}, 1);
        expect_wr(7'd3, 8'hB2, "R5");
        i2c_wbyte(8'hB2, ack);
        expect_wr(7'd4, 8'hC3, "R5");
        i2c_wbyte(8'hC3, ack);
        i2c_stop();

        // R2: other address is not acknowledged, rest ignored
        i2c_start();
        i2c_wbyte(8'h30, ack); check(!ack, "R2", "wrong address NACK", {31'd0, ack}, 0);
        i2c_wbyte(8'h05, ack);
        i2c_wbyte(8'h99, ack);
        i2c_stop();

        // R4: no increment, both writes hit register 5
        i2c_start();
        i2c_wbyte(8'h32, ack);
        i2c_wbyte(8'h05, ack);
        expect_wr(7'd5, 8'h11, "R4");
        i2c_wbyte(8'h11, ack);
        expect_wr(7'd5, 8'h22, "R4");
        i2c_wbyte(8'h22, ack);
        i2c_stop();

        // R6/R5: set pointer 1 with increment, then read three bytes
        i2c_start(); i2c_wbyte(8'h32, ack); i2c_wbyte(8'h81, ack); i2c_stop();
        i2c_start();
        i2c_wbyte(8'h33, ack); check(ack, "R6", "read address ACK", {31'd0, ack}, 1);
        i2c_rbyte(1'b1, rv); check(rv == 8'h11, "R6", "read reg1", {24'd0, rv}, 32'h11);
        i2c_rbyte(1'b1, rv); check(rv == 8'hA1, "R5", "read reg2", {24'd0, rv}, 32'hA1);
        i2c_rbyte(1'b0, rv); check(rv == 8'hB2, "R5", "read reg3", {24'd0, rv}, 32'hB2);
        i2c_stop();

        // R4: read without increment repeats register 4
        i2c_start(); i2c_wbyte(8'h32, ack); i2c_wbyte(8'h04, ack); i2c_stop();
        i2c_start(); i2c_wbyte(8'h33, ack);
        i2c_rbyte(1'b1, rv); check(rv == 8'hC3, "R4", "read reg4 first", {24'd0, rv}, 32'hC3);
        i2c_rbyte(1'b0, rv); check(rv == 8'hC3, "R4", "read reg4 again", {24'd0, rv}, 32'hC3);
        i2c_stop();

        // R7: writes past the last register are dropped but acknowledged
        i2c_start(); i2c_wbyte(8'h32, ack); i2c_wbyte(8'h86, ack);
        expect_wr(7'd6, 8'hD0, "R7");
        i2c_wbyte(8'hD0, ack);
        expect_wr(7'd7, 8'hD1, "R7");
        i2c_wbyte(8'hD1, ack);
        i2c_wbyte(8'hD2, ack); check(ack, "R7", "ACK past last", {31'd0, ack}, 1);
        i2c_stop();

        // R7: read past the last register returns zero
        i2c_start(); i2c_wbyte(8'h32, ack); i2c_wbyte(8'h87, ack); i2c_stop();
        i2c_start(); i2c_wbyte(8'h33, ack);
        i2c_rbyte(1'b1, rv); check(rv == 8'hD1, "R7", "read reg7", {24'd0, rv}, 32'hD1);
        i2c_rbyte(1'b0, rv); check(rv == 8'h00, "R7", "read past last", {24'd0, rv}, 0);
        i2c_stop();
        check(spi_mode == 1'b0, "R8", "still I2C before falling edge", {31'd0, spi_mode}, 0);

        // R8/R9: first chip-select fall switches to SPI; increment frame
        expect_wr(7'd0, 8'h5A, "R9");
        expect_wr(7'd1, 8'h6B, "R9");
        spi_frame3(8'h30, 8'h80, 8'h5A, 8'h6B);
        check(spi_mode == 1'b1, "R8", "SPI after falling edge", {31'd0, spi_mode}, 1);

        // R4 in SPI: fixed pointer
        expect_wr(7'd3, 8'h01, "R4");
        expect_wr(7'd3, 8'h02, "R4");
        spi_frame3(8'h30, 8'h03, 8'h01, 8'h02);

        // R9: wrong chip byte ignores the frame
        spi_frame3(8'h31, 8'h80, 8'h77, 8'h78);

        // R7 in SPI: write past last dropped
        expect_wr(7'd7, 8'hE1, "R7");
        spi_frame3(8'h30, 8'h87, 8'hE1, 8'hE2);

        // R10: I2C traffic in SPI mode is ignored
        i2c_start();
        i2c_wbyte(8'h32, ack); check(!ack, "R10", "no ACK in SPI mode", {31'd0, ack}, 0);
        i2c_wbyte(8'h80, ack);
        i2c_wbyte(8'h44, ack);
        i2c_stop();
        check(sda_oe == 1'b0, "R10", "SDA released in SPI mode", {31'd0, sda_oe}, 0);
        check(spi_mode == 1'b1, "R8", "SPI mode kept after CS edges", {31'd0, spi_mode}, 1);

        wait_cyc(20);
        check(exp_q.size() == 0, "R3", "all expected writes seen", exp_q.size(), 0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule